// File: doc/BRIEF.md
# Write-Once Watchdog Timer

This block is a watchdog that counts ticks from a slow timebase and raises a reset request when software fails to service it in time. Software services it by writing any value to one fixed bus address. That write clears the tick counter and restarts the timeout window.

The timeout length comes from a 2-bit rate code held in a small control register. The code is taken only from the first write to that register after reset. Every later write is ignored until the next system reset. The watchdog runs from reset onwards with the default code. It keeps counting while the device sits in wait mode, and it freezes while stop mode is active. The system reset generator that consumes the request lies outside this block.

Top module: `wdt_write_once`

## Requirements
- R1: While `rst` is high, `wdt_reset_req` is low, the tick count is zero, the rate code returns to 00 and the control register is unlocked. After reset the watchdog counts at once.
- R2: A bus write of any data to `SVC_ADDR` (default 0xFFFF) clears the tick count. If a tick arrives in the same cycle, the service write wins and that tick is not counted.
- R3: With rate code c, `wdt_reset_req` goes high in the cycle after the edge that samples the (`BASE_TICKS` << c)-th counted tick since the last clear.
- R4: The first write to `CTRL_ADDR` (default 0x0040) after reset loads the rate code from data bits [1:0] and locks the register. Later writes leave the code unchanged until reset.
- R5: Any write to `CTRL_ADDR` counts as the first write, whatever the other data bits hold. This includes a read-modify-write of an unrelated bit. It locks the code at the value carried in bits [1:0], 00 included.
- R6: Without any control write the code stays 00, giving a timeout of `BASE_TICKS` ticks.
- R7: While `stop_mode` is high, ticks are not counted and the count holds its value.
- R8: While `wait_mode` is high, ticks are counted exactly as in run mode.
- R9: `wdt_reset_req` is high for exactly one cycle. The count then restarts from zero, so the next request follows another full timeout.
- R10: Writes to any other address change neither the count nor the rate code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | ADDR_W | Bus write address |
| bus_wdata | input | DATA_W | Bus write data; bits [1:0] carry the rate code |
| tick | input | 1 | One-cycle timebase tick |
| wait_mode | input | 1 | Device is in wait mode |
| stop_mode | input | 1 | Device is in stop mode |
| wdt_reset_req | output | 1 | One-cycle reset request on timeout |

## Verification
Every input takes effect at one clock edge: a tick, a service write or a control write. The reset request is registered, so it is visible right after the edge that samples the terminal tick. The bench drives each stimulus for exactly one cycle on the falling edge. It samples `wdt_reset_req` on the next falling edge, so the tick that caused a pulse is the one just counted. Timeouts are measured by counting ticks until the pulse appears and comparing the count with `BASE_TICKS << code`. A service write, stop interval or foreign write in the middle of a window shows up as a shifted count.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    typedef enum logic [1:0] {
        RATE_X1 = 2'd0,
        RATE_X2 = 2'd1,
        RATE_X4 = 2'd2,
        RATE_X8 = 2'd3
    } wdt_rate_e;

    localparam int RATE_W     = 2;
    localparam int MAX_SHIFT  = 3;

    typedef struct packed {
        logic svc_hit;
        logic ctrl_hit;
    } wdt_bus_hit_t;

    typedef struct packed {
        wdt_rate_e rate;
        logic      locked;
    } wdt_ctrl_t;

    // Ticks in one timeout window for a given rate code
    function automatic int unsigned window_ticks(input wdt_rate_e rate, input int unsigned base);
        return base << int'(rate);
    endfunction

    // Counter width that holds the largest window
    function automatic int cnt_width(input int unsigned base);
        return $clog2(base << MAX_SHIFT) + 1;
    endfunction

endpackage

// File: rtl/wdt_bus_decode.sv
module wdt_bus_decode
    import wdt_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              DATA_W    = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR  = '1,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output wdt_bus_hit_t      hit,
    output wdt_rate_e         rate_field
);

    always_comb begin
        hit.svc_hit  = bus_wr && (bus_addr == SVC_ADDR);
        hit.ctrl_hit = bus_wr && (bus_addr == CTRL_ADDR);
        rate_field   = wdt_rate_e'(bus_wdata[RATE_W-1:0]);
    end

    AST_CTRL_DATA_KNOWN: assert property (@(posedge clk) disable iff (rst)
        hit.ctrl_hit |-> !$isunknown(bus_wdata)) else $error("ctrl data unknown"); // R5

    AST_HITS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        $countones({hit.svc_hit, hit.ctrl_hit}) <= 1) else $error("double decode"); // R10

endmodule

// File: rtl/wdt_rate_lock.sv
module wdt_rate_lock
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ctrl_hit,
    input  wdt_rate_e rate_field,
    output wdt_ctrl_t ctrl
);

    wdt_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.rate   <= RATE_X1;
            ctrl_q.locked <= 1'b0;
        end else if (ctrl_hit && !ctrl_q.locked) begin
            ctrl_q.rate   <= rate_field;
            ctrl_q.locked <= 1'b1;
        end
    end

    assign ctrl = ctrl_q;

    AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.locked |=> ctrl_q.locked) else $error("lock dropped"); // R4

    AST_RATE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.locked |=> $stable(ctrl_q.rate)) else $error("rate changed after lock"); // R4

    AST_FIRST_WRITE_LOCKS: assert property (@(posedge clk) disable iff (rst)
        ctrl_hit |=> ctrl_q.locked) else $error("write did not lock"); // R5

endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             svc,
    input  logic             wait_mode,
    input  logic             stop_mode,
    input  logic [CNT_W-1:0] last_cnt,
    output logic             req
);

    logic [CNT_W-1:0] cnt_q;
    logic             req_q;
    logic             step;

    assign step = tick && !stop_mode;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            req_q <= 1'b0;
        end else begin
            req_q <= 1'b0;
            if (svc) begin
                cnt_q <= '0;
            end else if (step) begin
                if (cnt_q >= last_cnt) begin
                    cnt_q <= '0;
                    req_q <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign req = req_q;

    AST_SERVICE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        svc |=> (cnt_q == '0) && !req_q) else $error("service missed"); // R2

    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (stop_mode && !svc) |=> $stable(cnt_q) && !req_q) else $error("counted in stop"); // R7

    AST_WAIT_COUNTS: assert property (@(posedge clk) disable iff (rst)
        (wait_mode && tick && !stop_mode && !svc && cnt_q < last_cnt)
        |=> cnt_q == $past(cnt_q) + 1'b1) else $error("wait mode blocked count"); // R8

    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        req_q |=> !req_q) else $error("request longer than one cycle"); // R9

    AST_REQ_RESTART: assert property (@(posedge clk) disable iff (rst)
        req_q |-> cnt_q == '0) else $error("count not restarted"); // R9

    AST_REQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        req_q |-> $past(tick && !stop_mode && !svc)) else $error("request without tick"); // R3

endmodule

// File: rtl/wdt_write_once.sv
module wdt_write_once
    import wdt_pkg::*;
#(
    parameter int                BASE_TICKS = 32,
    parameter int                ADDR_W     = 16,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] SVC_ADDR   = 16'hFFFF,
    parameter logic [ADDR_W-1:0] CTRL_ADDR  = 16'h0040
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              tick,
    input  logic              wait_mode,
    input  logic              stop_mode,
    output logic              wdt_reset_req
);

    localparam int CNT_W = cnt_width(BASE_TICKS);

    wdt_bus_hit_t     hit;
    wdt_rate_e        rate_field;
    wdt_ctrl_t        ctrl;
    logic [CNT_W-1:0] last_cnt;

    wdt_bus_decode #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .SVC_ADDR (SVC_ADDR),
        .CTRL_ADDR(CTRL_ADDR)
    ) u_dec (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .hit       (hit),
        .rate_field(rate_field)
    );

    wdt_rate_lock u_lock (
        .clk       (clk),
        .rst       (rst),
        .ctrl_hit  (hit.ctrl_hit),
        .rate_field(rate_field),
        .ctrl      (ctrl)
    );

    assign last_cnt = CNT_W'(window_ticks(ctrl.rate, BASE_TICKS) - 1);

    wdt_tick_counter #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .svc      (hit.svc_hit),
        .wait_mode(wait_mode),
        .stop_mode(stop_mode),
        .last_cnt (last_cnt),
        .req      (wdt_reset_req)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> !wdt_reset_req) else $error("request out of reset"); // R1

endmodule

// File: tb/tb_wdt_write_once.sv
module tb_wdt_write_once;

    localparam int BASE = 4;
    localparam logic [15:0] SVC  = 16'hFFFF;
    localparam logic [15:0] CTRL = 16'h0040;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        tick = 1'b0;
    logic        wait_mode = 1'b0;
    logic        stop_mode = 1'b0;
    logic        wdt_reset_req;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wdt_write_once #(.BASE_TICKS(BASE)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .tick(tick), .wait_mode(wait_mode),
        .stop_mode(stop_mode), .wdt_reset_req(wdt_reset_req)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic t, input logic w, input logic [15:0] a, input logic [7:0] d);
        tick = t; bus_wr = w; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        tick = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic ticks(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 1'b0, '0, '0);
            check(req, int'(wdt_reset_req), 0);
        end
    endtask

    // ticks until the request appears, 0 if none within 200
    task automatic measure(output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            cyc(1'b1, 1'b0, '0, '0);
            if (wdt_reset_req) begin
                n = i;
                break;
            end
        end
    endtask

    initial begin
        int n;
        @(negedge clk);
        do_reset();
        check("R1", int'(wdt_reset_req), 0);
        measure(n);
        check("R6", n, BASE);

        for (int c = 0; c < 4; c++) begin
            do_reset();
            cyc(1'b0, 1'b1, CTRL, 8'hA4 | 8'(c));
            cyc(1'b0, 1'b1, CTRL, 8'(c ^ 3));
            measure(n);
            check("R4", n, BASE << c);
            cyc(1'b0, 1'b0, '0, '0);
            check("R9", int'(wdt_reset_req), 0);
            measure(n);
            check("R9", n, BASE << c);
            measure(n);
            check("R3", n, BASE << c);
        end

        do_reset();
        cyc(1'b0, 1'b1, CTRL, 8'h80);
        cyc(1'b0, 1'b1, CTRL, 8'h03);
        measure(n);
        check("R5", n, BASE);

        do_reset();
        cyc(1'b0, 1'b1, CTRL, 8'h01);
        ticks(2 * BASE - 1, "R2");
        cyc(1'b0, 1'b1, SVC, 8'h5A);
        check("R2", int'(wdt_reset_req), 0);
        measure(n);
        check("R2", n, 2 * BASE);
        ticks(5, "R2");
        cyc(1'b1, 1'b1, SVC, 8'h00);
        check("R2", int'(wdt_reset_req), 0);
        measure(n);
        check("R2", n, 2 * BASE);

        ticks(3, "R10");
        cyc(1'b0, 1'b1, 16'hFFFE, 8'h00);
        cyc(1'b0, 1'b1, 16'h0041, 8'h03);
        cyc(1'b0, 1'b1, CTRL, 8'h03);
        measure(n);
        check("R10", n, 2 * BASE - 3);

        do_reset();
        ticks(2, "R7");
        stop_mode = 1'b1;
        ticks(10, "R7");
        stop_mode = 1'b0;
        measure(n);
        check("R7", n, BASE - 2);

        wait_mode = 1'b1;
        measure(n);
        check("R8", n, BASE);
        wait_mode = 1'b0;

        cyc(1'b0, 1'b1, CTRL, 8'h00);
        ticks(3, "R1");
        do_reset();
        cyc(1'b0, 1'b1, CTRL, 8'h02);
        measure(n);
        check("R1", n, 4 * BASE);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule